// File: doc/BRIEF.md
# Configurable Lookup Logic Cell

This block is a small programmable logic element for a microcontroller peripheral set. Four external signals, A to D, enter the cell. Each one may pass through a two-stage synchronizer to the cell clock. Each of the two lookup tables then sees that vector through its own digital glitch filter. The filter samples at a programmable period and accepts a new input value only after the value has stayed the same for a programmable number of samples.

Each lookup table holds a 16-entry truth table. The four filtered inputs form the table index. The two table results can drive the outputs directly. They can instead go through a register stage, which acts either as a pair of D flip-flops or as one JK flip-flop. In JK mode the flip-flop state is fed back into the table index, and a selected input can take its place. Writing the control word can force the register stage to 0 or 1, or leave it as it is. A rising edge on output A can raise a one-cycle interrupt pulse. A rising edge on output B can raise a one-cycle DMA request pulse. Software configures the cell through a simple write-only register port that has three registers.

Top module: `cfg_logic_cell`

## Requirements
- R1: After reset, all configuration registers are zero, which selects D-register mode. `out_a`, `out_b`, `irq_pulse` and `dma_pulse` are all 0.
- R2: The table register is at address 1. Table 0 is in bits [15:0] and table 1 is in bits [31:16]. The lookup index is {D,C,B,A}, with A in bit 0. When the bypass bit (control bit 4) is set, `out_a` equals table0[index] and `out_b` equals table1[index], combinationally, with no clock delay.
- R3: The control register is at address 0. When control bit i (A=0 to D=3) is set, input i reaches the tables two clock edges after it changes. When the bit is clear, the input reaches the tables at once.
- R4: The filter register is at address 2. Table 0 uses period bits [7:0] and count bits [15:8]. Table 1 uses period bits [23:16] and count bits [31:24]. With count N > 0, a sample is taken every period+1 clocks. A new input vector is accepted after N consecutive equal samples that differ from the accepted vector. A change lasting fewer samples is never seen. With period 0 and count 3, acceptance comes on the third edge.
- R5: With count 0, the filter is transparent for its table.
- R6: In D mode (control bits 4 and 5 both clear), `out_a` and `out_b` take table0 and table1 at each clock edge.
- R7: In JK mode (bit 5 set, bit 4 clear), table 0 gives J and table 1 gives K. At each edge, J=1,K=0 sets the state, J=0,K=1 clears it, J=K=1 toggles it and J=K=0 holds it. `out_a` is the state and `out_b` is its complement.
- R8: In JK mode, index bit 3 is replaced by the flip-flop state. When control bit 8 is set, it is instead replaced by the input selected by control bits [10:9] (0=A to 3=D).
- R9: A control write whose bits [7:6] are 00 forces the register stage to 0, and one with 01 forces it to 1. This forcing wins over capture at the same edge. A write with bit 7 set leaves the stage as it is.
- R10: When control bit 11 is set, each rising edge of `out_a` gives one high cycle of `irq_pulse` on the next edge. A rising edge of `out_b` never raises it.
- R11: When control bit 12 is set, each rising edge of `out_b` gives one high cycle of `dma_pulse` on the next edge. A rising edge of `out_a` never raises it.
- R12: A write to address 3 changes no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| pin_in | input | 4 | External inputs, bit 0 = A through bit 3 = D |
| out_a | output | 1 | Cell output A |
| out_b | output | 1 | Cell output B |
| irq_pulse | output | 1 | Interrupt pulse from output A |
| dma_pulse | output | 1 | DMA request pulse from output B |

## Verification
Random truth tables and random input vectors are applied in bypass mode, which confirms that the index order is right. The same is done in D mode, which confirms the one-edge capture delay, and in JK mode, where a bench model tracks the set, clear, toggle and hold outcomes. Directed cases cover the rest. A single synchronized input is compared with an unsynchronized neighbour to show the two-edge skew. A two-cycle glitch is compared with a held value to show that the filter rejects one and accepts the other, and a period of 1 shows the slower sampling. A table that depends only on index bit 3 tells the state feedback apart from the override input. Further cases cover the forced 0 and 1 values against keep, and interrupt and DMA pulses with their enables set and clear.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_TABLE = 1;
  localparam int ADDR_FILT  = 2;

  // control fields as stored; the force field [7:6] acts only at write time
  typedef struct packed {
    logic       dma_en;   // bit 12
    logic       irq_en;   // bit 11
    logic [1:0] fb_sel;   // bits 10:9
    logic       fb_en;    // bit 8
    logic       jk;       // bit 5
    logic       bypass;   // bit 4
    logic [3:0] sync_en;  // bits 3:0
  } ctrl_t;
endpackage

// File: rtl/lc_input_filter.sv
module lc_input_filter #(
  parameter int W     = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     raw,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] count,
  output logic [W-1:0]     filt
);
  logic [CNT_W-1:0] pc_q, pc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     cand_q, cand_d;
  logic [W-1:0]     acc_q, acc_d;
  logic [CNT_W:0]   run;
  logic             tick;
  logic             bypass;

  assign tick   = (pc_q >= period);
  assign bypass = (count == '0);

  always_comb begin
    pc_d   = tick ? '0 : pc_q + 1'b1;
    cnt_d  = cnt_q;
    cand_d = cand_q;
    acc_d  = acc_q;
    run    = ((raw == cand_q) && (cnt_q != '0)) ? {1'b0, cnt_q} + 1'b1 : (CNT_W+1)'(1);
    if (bypass) begin
      acc_d = raw;
      cnt_d = '0;
    end else if (tick) begin
      if (raw == acc_q) begin
        cnt_d = '0;
      end else if (run >= {1'b0, count}) begin
        acc_d = raw;
        cnt_d = '0;
      end else begin
        cand_d = raw;
        cnt_d  = run[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      cnt_q  <= '0;
      cand_q <= '0;
      acc_q  <= '0;
    end else begin
      pc_q   <= pc_d;
      cnt_q  <= cnt_d;
      cand_q <= cand_d;
      acc_q  <= acc_d;
    end
  end

  assign filt = bypass ? raw : acc_q;
endmodule

// File: rtl/lc_lut.sv
module lc_lut #(
  parameter int N_IN = 4,
  localparam int TBL_W = 1 << N_IN
) (
  input  logic [TBL_W-1:0] table_bits,
  input  logic [N_IN-1:0]  idx,
  output logic             y
);
  assign y = table_bits[idx];
endmodule

// File: rtl/lc_ff_stage.sv
module lc_ff_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_all,
  input  logic jk_mode,
  input  logic d0,
  input  logic d1,
  input  logic force_en,
  input  logic force_val,
  output logic q_a,
  output logic q_b
);
  logic qa_d, qb_d, en;

  assign en = force_en | ~hold_all;

  always_comb begin
    qa_d = q_a;
    qb_d = q_b;
    if (force_en) begin
      qa_d = force_val;
      qb_d = force_val;
    end else if (jk_mode) begin
      unique case ({d0, d1})
        2'b10:   qa_d = 1'b1;
        2'b01:   qa_d = 1'b0;
        2'b11:   qa_d = ~q_a;
        default: qa_d = q_a;
      endcase
    end else begin
      qa_d = d0;
      qb_d = d1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_a <= 1'b0;
      q_b <= 1'b0;
    end else if (en) begin
      q_a <= qa_d;
      q_b <= qb_d;
    end
  end
endmodule

// File: rtl/lc_edge_pulse.sv
module lc_edge_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl,
  output logic pulse
);
  logic prev_q, pulse_d;

  assign pulse_d = en & lvl & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      prev_q <= lvl;
      pulse  <= pulse_d;
    end
  end
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import lc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [3:0]        pin_in,
  output logic              out_a,
  output logic              out_b,
  output logic              irq_pulse,
  output logic              dma_pulse
);
  localparam int N_IN   = 4;
  localparam int N_LUT  = 2;
  localparam int TBL_W  = 1 << N_IN;
  localparam int FLT_W  = 2 * CNT_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1_q  <= 1'b1;
      rst_int_n <= rst_s1_q;
    end
  end

  // configuration registers
  ctrl_t                    ctrl_q, ctrl_d;
  logic [N_LUT*TBL_W-1:0]   table_q, table_d;
  logic [N_LUT*FLT_W-1:0]   filt_q, filt_d;
  logic                     wr_ctrl, wr_table, wr_filt;

  assign wr_ctrl  = cfg_we && (cfg_addr == ADDR_W'(ADDR_CTRL));
  assign wr_table = cfg_we && (cfg_addr == ADDR_W'(ADDR_TABLE));
  assign wr_filt  = cfg_we && (cfg_addr == ADDR_W'(ADDR_FILT));

  always_comb begin
    ctrl_d  = ctrl_q;
    table_d = table_q;
    filt_d  = filt_q;
    if (wr_ctrl) begin
      ctrl_d.sync_en = cfg_wdata[3:0];
      ctrl_d.bypass  = cfg_wdata[4];
      ctrl_d.jk      = cfg_wdata[5];
      ctrl_d.fb_en   = cfg_wdata[8];
      ctrl_d.fb_sel  = cfg_wdata[10:9];
      ctrl_d.irq_en  = cfg_wdata[11];
      ctrl_d.dma_en  = cfg_wdata[12];
    end
    if (wr_table) table_d = cfg_wdata[N_LUT*TBL_W-1:0];
    if (wr_filt)  filt_d  = cfg_wdata[N_LUT*FLT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q  <= '0;
      table_q <= '0;
      filt_q  <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= ctrl_d;
      if (wr_table) table_q <= table_d;
      if (wr_filt)  filt_q  <= filt_d;
    end
  end

  // per-input optional synchronizer
  logic [N_IN-1:0] in_sel;
  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= pin_in[i];
        s2_q <= s1_q;
      end
    end
    assign in_sel[i] = ctrl_q.sync_en[i] ? s2_q : pin_in[i];
  end

  // mode decode
  logic ff_on, jk_on, q_a, q_b;
  assign ff_on = ~ctrl_q.bypass;
  assign jk_on = ctrl_q.jk & ff_on;

  // per-table filter, index build and lookup
  logic [N_LUT-1:0][N_IN-1:0] filt_vec;
  logic [N_LUT-1:0][N_IN-1:0] lut_idx;
  logic [N_LUT-1:0]           lut_y;
  for (genvar g = 0; g < N_LUT; g++) begin : g_lut
    logic fb_bit;
    lc_input_filter #(.W(N_IN), .CNT_W(CNT_W)) u_filt (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .raw    (in_sel),
      .period (filt_q[g*FLT_W +: CNT_W]),
      .count  (filt_q[g*FLT_W+CNT_W +: CNT_W]),
      .filt   (filt_vec[g])
    );
    assign fb_bit     = ctrl_q.fb_en ? filt_vec[g][ctrl_q.fb_sel] : q_a;
    assign lut_idx[g] = jk_on ? {fb_bit, filt_vec[g][N_IN-2:0]} : filt_vec[g];
    lc_lut #(.N_IN(N_IN)) u_lut (
      .table_bits (table_q[g*TBL_W +: TBL_W]),
      .idx        (lut_idx[g]),
      .y          (lut_y[g])
    );
  end

  // register stage
  logic force_en;
  assign force_en = wr_ctrl & ~cfg_wdata[7];

  lc_ff_stage u_ff (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hold_all  (ctrl_q.bypass),
    .jk_mode   (ctrl_q.jk),
    .d0        (lut_y[0]),
    .d1        (lut_y[1]),
    .force_en  (force_en),
    .force_val (cfg_wdata[6]),
    .q_a       (q_a),
    .q_b       (q_b)
  );

  assign out_a = ff_on ? q_a : lut_y[0];
  assign out_b = ff_on ? (jk_on ? ~q_a : q_b) : lut_y[1];

  // event pulses: interrupt from A, DMA request from B
  logic [1:0] ev_lvl, ev_en, ev_pulse;
  assign ev_lvl = {out_b, out_a};
  assign ev_en  = {ctrl_q.dma_en, ctrl_q.irq_en};
  for (genvar e = 0; e < 2; e++) begin : g_ev
    lc_edge_pulse u_ev (
      .clk   (clk),
      .rst_n (rst_int_n),
      .en    (ev_en[e]),
      .lvl   (ev_lvl[e]),
      .pulse (ev_pulse[e])
    );
  end
  assign irq_pulse = ev_pulse[0];
  assign dma_pulse = ev_pulse[1];
endmodule

// File: rtl/lc_checker.sv
module lc_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic out_a,
  input logic out_b,
  input logic irq_pulse,
  input logic dma_pulse,
  input logic ff_on,
  input logic jk_on,
  input logic j_in,
  input logic k_in
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R10
  AST_IRQ_FROM_A: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(out_a)); // R10
  AST_DMA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_pulse |=> !dma_pulse); // R11
  AST_DMA_FROM_B: assert property (@(posedge clk) disable iff (!rst_n)
    dma_pulse |-> $past(out_b)); // R11
  AST_D_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_on && !jk_on && $past(ff_on && !jk_on && !cfg_we))
      |-> (out_a == $past(j_in)) && (out_b == $past(k_in))); // R6
  AST_JK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (jk_on && $past(jk_on && !cfg_we && j_in && !k_in)) |-> out_a); // R7
  AST_JK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (jk_on && $past(jk_on && !cfg_we && !j_in && k_in)) |-> !out_a); // R7
endmodule

bind cfg_logic_cell lc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .cfg_we    (cfg_we),
  .out_a     (out_a),
  .out_b     (out_b),
  .irq_pulse (irq_pulse),
  .dma_pulse (dma_pulse),
  .ff_on     (ff_on),
  .jk_on     (jk_on),
  .j_in      (lut_y[0]),
  .k_in      (lut_y[1])
);

// File: tb/cfg_logic_cell_tb_top.sv
`timescale 1ns/1ps
module cfg_logic_cell_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [3:0]  pin_in;
  logic        out_a, out_b, irq_pulse, dma_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_logic_cell dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pin_in(pin_in), .out_a(out_a), .out_b(out_b),
    .irq_pulse(irq_pulse), .dma_pulse(dma_pulse)
  );

  function automatic logic tbl_bit(input logic [15:0] t, input logic [3:0] idx);
    return t[idx];
  endfunction

  function automatic logic jk_next(input logic q, input logic j, input logic k);
    if (j && !k) return 1'b1;
    if (!j && k) return 1'b0;
    if (j && k)  return ~q;
    return q;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] t;
    logic [31:0] p;
    logic        q;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; pin_in = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    // R1: reset state
    chk("R1 out_a", out_a, 1'b0);
    chk("R1 out_b", out_b, 1'b0);
    chk("R1 irq", irq_pulse, 1'b0);
    chk("R1 dma", dma_pulse, 1'b0);

    // R2: bypass, random tables and inputs
    wr(2'd0, 32'h10);
    for (int i = 0; i < 48; i++) begin
      if (i % 16 == 0) begin t = $urandom; wr(2'd1, t); end
      p = $urandom;
      pin_in = p[3:0];
      #1;
      chk("R2 out_a", out_a, tbl_bit(t[15:0], p[3:0]));
      chk("R2 out_b", out_b, tbl_bit(t[31:16], p[3:0]));
      @(negedge clk);
    end

    // R3: input A synchronized, B direct
    pin_in = '0;
    wr(2'd1, 32'hCCCC_AAAA);
    wr(2'd0, 32'h11);
    wait_n(3);
    pin_in = 4'b0011;
    #1;
    chk("R3 direct B", out_b, 1'b1);
    chk("R3 sync A t0", out_a, 1'b0);
    @(negedge clk);
    chk("R3 sync A t1", out_a, 1'b0);
    @(negedge clk);
    chk("R3 sync A t2", out_a, 1'b1);
    pin_in = '0;
    wait_n(3);
    wr(2'd0, 32'h10);

    // R4: table0 filter period 0 count 3; glitch rejected
    wr(2'd2, 32'h0000_0300);
    pin_in = 4'b0001;
    @(negedge clk); chk("R4 glitch e1", out_a, 1'b0);
    @(negedge clk); chk("R4 glitch e2", out_a, 1'b0);
    pin_in = 4'b0000;
    @(negedge clk); chk("R4 glitch gone", out_a, 1'b0);
    wait_n(3);      chk("R4 glitch later", out_a, 1'b0);
    pin_in = 4'b0011;
    #1;
    chk("R5 table1 transparent", out_b, 1'b1);
    @(negedge clk); chk("R4 hold e1", out_a, 1'b0);
    @(negedge clk); chk("R4 hold e2", out_a, 1'b0);
    @(negedge clk); chk("R4 hold e3", out_a, 1'b1);
    pin_in = 4'b0000;
    wait_n(5);
    chk("R4 back to 0", out_a, 1'b0);
    // period 1, count 2
    wr(2'd2, 32'h0000_0201);
    wait_n(1);
    pin_in = 4'b0001;
    wait_n(2); chk("R4 slow not yet", out_a, 1'b0);
    wait_n(2); chk("R4 slow accepted", out_a, 1'b1);
    pin_in = 4'b0000;
    wait_n(6);
    wr(2'd2, 32'h0);

    // R6: D mode capture
    t = $urandom;
    wr(2'd1, t);
    wr(2'd0, 32'h0);
    for (int i = 0; i < 32; i++) begin
      p = $urandom;
      pin_in = p[3:0];
      @(negedge clk);
      chk("R6 out_a", out_a, tbl_bit(t[15:0], p[3:0]));
      chk("R6 out_b", out_b, tbl_bit(t[31:16], p[3:0]));
    end

    // R7: JK, J = input A, K = input B
    pin_in = '0;
    wr(2'd1, 32'hCCCC_AAAA);
    wr(2'd0, 32'h20);
    q = 1'b0;
    chk("R9 force zero", out_a, 1'b0);
    chk("R7 complement", out_b, 1'b1);
    for (int i = 0; i < 32; i++) begin
      p = $urandom;
      pin_in = p[3:0];
      @(negedge clk);
      q = jk_next(q, p[0], p[1]);
      chk("R7 q", out_a, q);
      chk("R7 qbar", out_b, ~q);
    end

    // R8: feedback replaces D; override selects C
    pin_in = '0;
    wr(2'd1, 32'h0000_FF00);
    wr(2'd0, 32'h20);
    pin_in = 4'b1100;
    wait_n(3);
    chk("R8 feedback holds", out_a, 1'b0);
    wr(2'd0, 32'h5A0);
    chk("R8 old ctrl at write", out_a, 1'b0);
    @(negedge clk);
    chk("R8 override sets", out_a, 1'b1);
    pin_in = 4'b1000;
    wait_n(2);
    chk("R8 hold", out_a, 1'b1);

    // R9: force values
    wr(2'd0, 32'h5A0);
    chk("R9 keep", out_a, 1'b1);
    wr(2'd0, 32'h520);
    chk("R9 force 0", out_a, 1'b0);
    wr(2'd0, 32'h560);
    chk("R9 force 1", out_a, 1'b1);
    chk("R9 force 1 qbar", out_b, 1'b0);
    pin_in = '0;
    wr(2'd0, 32'h040);
    chk("R9 D force a", out_a, 1'b1);
    chk("R9 D force b", out_b, 1'b1);
    @(negedge clk);
    chk("R9 D capture after", out_a, 1'b0);
    chk("R9 D capture after b", out_b, 1'b0);

    // R10: interrupt from A
    wr(2'd1, 32'hCCCC_AAAA);
    wr(2'd0, 32'h810);
    wait_n(2);
    pin_in = 4'b0001;
    #1;
    chk("R10 not yet", irq_pulse, 1'b0);
    @(negedge clk); chk("R10 pulse", irq_pulse, 1'b1);
    @(negedge clk); chk("R10 single", irq_pulse, 1'b0);
    pin_in = 4'b0011;
    @(negedge clk);
    chk("R11 dma off", dma_pulse, 1'b0);
    chk("R10 B edge no irq", irq_pulse, 1'b0);
    pin_in = '0;
    wr(2'd0, 32'h1010);
    wait_n(2);
    pin_in = 4'b0010;
    @(negedge clk);
    chk("R11 pulse", dma_pulse, 1'b1);
    chk("R10 irq off", irq_pulse, 1'b0);
    @(negedge clk); chk("R11 single", dma_pulse, 1'b0);
    pin_in = 4'b0011;
    @(negedge clk);
    chk("R10 disabled", irq_pulse, 1'b0);
    chk("R11 A edge no dma", dma_pulse, 1'b0);

    // R12: address 3 ignored
    pin_in = '0;
    wait_n(2);
    wr(2'd3, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) begin
      p = $urandom;
      pin_in = p[3:0];
      #1;
      chk("R12 out_a", out_a, tbl_bit(16'hAAAA, p[3:0]));
      chk("R12 out_b", out_b, tbl_bit(16'hCCCC, p[3:0]));
      @(negedge clk);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule